// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine of a byte-addressed serial memory on a two-wire bus. Both bus lines are resynchronised to the system clock, which runs at least eight times faster than the bus clock. Start and stop conditions are found on that clock. A selection byte is compared against a fixed type code and three strap pins. A two-byte memory address sets one shared address counter. Read data comes from an internal synchronous array. The engine pulls the data line low through an open-drain enable and otherwise leaves it released.

Received write data is not stored here. Each data byte leaves on a one-cycle handoff strobe, together with the address it belongs to, for a separate page buffer. That buffer commits programmed bytes back into the array through a commit port. It also raises a busy input while its program cycle runs. The engine holds one address counter for reads and writes. A random read is built from an address-only write frame followed by a repeated start in read mode.

The state machine has these states. ST_IDLE waits for a start. ST_DEV receives the selection byte and ST_DEV_ACK acknowledges it. ST_AHI and ST_AHI_ACK handle the high address byte. ST_ALO and ST_ALO_ACK handle the low address byte. ST_WDATA and ST_WDATA_ACK receive write bytes. ST_RDATA sends a read byte and ST_RACK samples the master's acknowledge.

A start moves any state to ST_DEV, and a stop moves any state to ST_IDLE. ST_DEV goes to ST_DEV_ACK on a match and otherwise to ST_IDLE. ST_DEV_ACK goes to ST_RDATA for a read and to ST_AHI for a write. The address and data states alternate with their acknowledge states: AHI, then ALO, then WDATA, which repeats. ST_RDATA goes to ST_RACK after eight bits. ST_RACK goes back to ST_RDATA when the master acknowledges and to ST_IDLE when it does not.

Top module: `tw_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It restarts byte reception from any state, including in the middle of a byte. A rising data line while the clock is high is a stop, which returns the engine to idle with the line released.
- R2: The selection byte is sent MSB first. Its bits 7:4 must be 1010 and its bits 3:1 must equal the strap pins. Bit 0 selects the direction: 1 is read and 0 is write. A byte that does not match gets no acknowledge, and the line stays released until the next start.
- R3: While the busy input is high, a matching selection byte gets no acknowledge.
- R4: In a write frame, the two bytes after the selection byte are acknowledged and loaded into the 16-bit address counter, high byte first.
- R5: A read frame that follows an address-only write frame and a repeated start returns the byte stored at the loaded address.
- R6: A read frame with no address phase returns the byte at the address after the last one read or written.
- R7: While the master acknowledges, read bytes keep coming at consecutive addresses, and the counter wraps from 0xFFFF to 0x0000. After a master no-acknowledge the line is released.
- R8: A read from an address whose bits above the array width are not all zero returns 0xFF.
- R9: Each received write byte gives one handoff strobe carrying the byte and the counter value. The counter then advances only in its low seven bits, so it wraps within a 128-byte page.
- R10: Read bytes are sent MSB first. The open-drain enable changes only while the synchronised clock is low.
- R11: After reset the line is released, the handoff strobe is low and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when high |
| strap | input | 3 | Board strap bits for address matching |
| wr_busy | input | 1 | Program cycle in progress in the page buffer |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 16 | Address of the handed-off byte |
| wr_data | output | 8 | Handed-off byte |
| pg_we | input | 1 | Commit strobe from the page buffer |
| pg_addr | input | MEM_AW | Commit address into the array |
| pg_data | input | 8 | Commit data |

## Verification
The hardest situations to reach are the counter wrap from 0xFFFF to 0x0000 and the page wrap of write addresses. Both need an exact address frame before the data phase. The stimulus loads 0xFFFE and reads three bytes in one sequential frame. It then writes two bytes starting at 0x00FF and checks the handoff addresses. A start in the middle of a byte is forced by cutting a selection byte short after three bits. The next frame must then still be decoded correctly.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tw_state_e;
endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES synchroniser flops plus one history flop per line
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_q     = scl_pipe[STAGES-1];
    assign sda_q     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_pipe[STAGES-1] & ~scl_pipe[STAGES];
    assign scl_fall  = ~scl_pipe[STAGES-1] & scl_pipe[STAGES];
    assign start_det = scl_pipe[STAGES-1] & scl_pipe[STAGES] & sda_pipe[STAGES] & ~sda_pipe[STAGES-1];
    assign stop_det  = scl_pipe[STAGES-1] & scl_pipe[STAGES] & ~sda_pipe[STAGES] & sda_pipe[STAGES-1];
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int PAGE_AW     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap,
    input  logic              wr_busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              pg_we,
    input  logic [MEM_AW-1:0] pg_addr,
    input  logic [BYTE_W-1:0] pg_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    tw_state_e         state_q, state_d;
    logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, addr_hi, mem_q, rd_byte;
    logic [ADDR_W-1:0] ctr, ctr_page;
    logic [PAGE_AW-1:0] page_low;
    logic              ack_drv, mack, rw_q;
    logic              rx_state, ack_state, byte_done, dev_hit, in_range;

    tw_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_mem_array #(.AW(MEM_AW), .DW(BYTE_W)) u_array (
        .clk(clk), .we(pg_we), .waddr(pg_addr), .wdata(pg_data),
        .raddr(ctr[MEM_AW-1:0]), .rdata(mem_q)
    );

    assign rx_state  = state_q inside {ST_DEV, ST_AHI, ST_ALO, ST_WDATA};
    assign ack_state = state_q inside {ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK};
    assign byte_done = rx_state && scl_fall && (bit_cnt == FULL_CNT);
    assign dev_hit   = (shreg[7:1] == {DEV_TYPE, strap}) && !wr_busy;
    assign in_range  = (ctr[ADDR_W-1:MEM_AW] == '0);
    assign rd_byte   = in_range ? mem_q : '1;
    assign page_low  = ctr[PAGE_AW-1:0] + PAGE_AW'(1);
    assign ctr_page  = {ctr[ADDR_W-1:PAGE_AW], page_low};
    assign sda_oe    = ack_drv | ((state_q == ST_RDATA) & ~shreg[BYTE_W-1]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_done) state_d = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_d = rw_q ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_done) state_d = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall) state_d = ST_ALO;
                ST_ALO:       if (byte_done) state_d = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == LAST_BIT) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            ctr      <= '0;
            ack_drv  <= 1'b0;
            mack     <= 1'b0;
            rw_q     <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                ack_drv <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_q};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (byte_done) begin
                    bit_cnt <= '0;
                    ack_drv <= (state_q == ST_DEV) ? dev_hit : 1'b1;
                    case (state_q)
                        ST_DEV:  rw_q    <= shreg[0];
                        ST_AHI:  addr_hi <= shreg;
                        ST_ALO:  ctr     <= {addr_hi, shreg};
                        default: begin
                            wr_valid <= 1'b1;
                            wr_addr  <= ctr;
                            wr_data  <= shreg;
                            ctr      <= ctr_page;
                        end
                    endcase
                end
            end else if (ack_state) begin
                if (scl_fall) begin
                    ack_drv <= 1'b0;
                    bit_cnt <= '0;
                    if (state_q == ST_DEV_ACK && rw_q) begin
                        shreg <= rd_byte;
                        ctr   <= ctr + ADDR_W'(1);
                    end
                end
            end else if (state_q == ST_RDATA) begin
                if (scl_fall) begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                    end else begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
            end else if (state_q == ST_RACK) begin
                if (scl_rise) mack <= ~sda_q;
                if (scl_fall && mack) begin
                    shreg   <= rd_byte;
                    ctr     <= ctr + ADDR_W'(1);
                    bit_cnt <= '0;
                end
            end
        end
    end

    // R10: the line driver moves only in the clock-low phase
    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_q);

    // R3: entry into the selection acknowledge never happens while busy
    a_r3_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DEV_ACK) |-> $past(!wr_busy));

    // R2: the acknowledge drive is only ever present in an acknowledge phase
    a_r2_ack_in_ack_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drv |-> ack_state);

    // R11: an idle engine leaves the line released
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    // R9: handoff strobes come only from the write data phase
    a_r9_wr_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(state_q == ST_WDATA));
endmodule

// File: tb/test_tw_mem_slave.sv
module test_tw_mem_slave;
    localparam int Q = 5;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;
    localparam int NVEC = 7;
    // {address, expected byte}; array is preloaded with addr[7:0] ^ 8'h5A
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00005A, 24'h00114B, 24'h0080DA, 24'h003C66,
        24'h00FFA5, 24'h0100FF, 24'h8000FF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic wr_busy = 1'b0;
    logic wr_valid;
    logic [15:0] wr_addr;
    logic [7:0] wr_data;
    logic pg_we = 1'b0;
    logic [7:0] pg_addr = '0;
    logic [7:0] pg_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_cap = 0;
    logic [15:0] cap_addr [4];
    logic [7:0]  cap_data [4];

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tw_mem_slave i_tw_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap(STRAP), .wr_busy(wr_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data)
    );

    always @(negedge clk) begin
        if (wr_valid && n_cap < 4) begin
            cap_addr[n_cap] = wr_addr;
            cap_data[n_cap] = wr_data;
            n_cap++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q;
        repeat (Q) @(posedge clk);
        #2;
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;
        wait_q;
        scl_m = 1'b1;
        wait_q;
        seen = sda_line;
        wait_q;
        scl_m = 1'b0;
        wait_q;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b1; wait_q;
        wait_q;
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(!give_ack, s);
    endtask

    task automatic set_addr(input logic [15:0] a, output logic ok);
        logic k0, k1, k2;
        bus_start;
        tx_byte(DEV_W, k0);
        tx_byte(a[15:8], k1);
        tx_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] d, output logic ok);
        logic k0, k1;
        set_addr(a, k0);
        bus_start;
        tx_byte(DEV_R, k1);
        rx_byte(1'b0, d);
        bus_stop;
        ok = k0 & k1;
    endtask

    task automatic cur_read(output logic [7:0] d, output logic ok);
        bus_start;
        tx_byte(DEV_R, ok);
        rx_byte(1'b0, d);
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic ok, s;
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check("R11 sda_oe in reset", 32'(sda_oe), 32'd0);
        check("R11 wr_valid in reset", 32'(wr_valid), 32'd0);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            pg_we = 1'b1;
            pg_addr = 8'(a);
            pg_data = 8'(a) ^ 8'h5A;
        end
        @(negedge clk);
        pg_we = 1'b0;
        rst_n = 1'b1;
        wait_q;
        check("R11 sda_oe after reset", 32'(sda_oe), 32'd0);

        // R5 / R8 random reads from the vector table
        for (int k = 0; k < NVEC; k++) begin
            rand_read(VEC[k][23:8], d, ok);
            check("R4 address phase acknowledged", 32'(ok), 32'd1);
            check(VEC[k][23:16] != 8'h00 || VEC[k][15:8] > 8'hFF ? "R8 out-of-range read" : "R5 random read",
                  32'(d), 32'(VEC[k][7:0]));
        end

        // R6 current-address read after a random read of 0x0011
        rand_read(16'h0011, d, ok);
        cur_read(d, ok);
        check("R6 current read ack", 32'(ok), 32'd1);
        check("R6 current read data", 32'(d), 32'h48);

        // R7 sequential read wrapping 0xFFFF -> 0x0000
        set_addr(16'hFFFE, ok);
        bus_start;
        tx_byte(DEV_R, ok);
        rx_byte(1'b1, d);
        check("R7 seq byte 0xFFFE", 32'(d), 32'hFF);
        rx_byte(1'b1, d);
        check("R7 seq byte 0xFFFF", 32'(d), 32'hFF);
        rx_byte(1'b0, d);
        check("R7 seq byte wrapped to 0", 32'(d), 32'h5A);
        check("R7 released after nack", 32'(sda_oe), 32'd0);
        bus_stop;
        cur_read(d, ok);
        check("R7 counter after wrap", 32'(d), 32'h5B);

        // R2 non-matching strap
        bus_start;
        tx_byte(8'hA6, ok);
        check("R2 wrong strap no ack", 32'(ok), 32'd0);
        bus_bit(1'b1, s);
        check("R2 line released after mismatch", 32'(s), 32'd1);
        bus_stop;

        // R3 busy input blocks acknowledge
        wr_busy = 1'b1;
        bus_start;
        tx_byte(DEV_W, ok);
        check("R3 no ack while busy", 32'(ok), 32'd0);
        bus_stop;
        wr_busy = 1'b0;
        bus_start;
        tx_byte(DEV_W, ok);
        check("R3 ack once idle", 32'(ok), 32'd1);
        bus_stop;
        check("R1 released after stop", 32'(sda_oe), 32'd0);

        // R9 write handoff with page wrap
        set_addr(16'h00FF, ok);
        tx_byte(8'hC3, ok);
        check("R9 data byte 0 ack", 32'(ok), 32'd1);
        tx_byte(8'h3C, ok);
        check("R9 data byte 1 ack", 32'(ok), 32'd1);
        bus_stop;
        check("R9 handoff count", 32'(n_cap), 32'd2);
        check("R9 first address", 32'(cap_addr[0]), 32'h00FF);
        check("R9 first data", 32'(cap_data[0]), 32'hC3);
        check("R9 page-wrapped address", 32'(cap_addr[1]), 32'h0080);
        check("R9 second data", 32'(cap_data[1]), 32'h3C);
        cur_read(d, ok);
        check("R6 read after write", 32'(d), 32'hDB);

        // R1 start in the middle of a byte restarts reception
        bus_start;
        bus_bit(1'b1, s);
        bus_bit(1'b0, s);
        bus_bit(1'b1, s);
        rand_read(16'h003C, d, ok);
        check("R1 restart acknowledged", 32'(ok), 32'd1);
        check("R1 restart read data (R10 MSB first)", 32'(d), 32'h66);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule